// File: doc/BRIEF.md
# Flash Protected Range Guard

This block decides whether a flash cycle may start. It holds five range registers, each naming a span of 4 KiB pages in a 25-bit linear flash space. Each range has its own enable for reads and its own enable for writes, and the write enable also covers erase. Before a cycle starts, the sequencer presents the linear address and the direction of the cycle. The guard answers at once with a block signal, which the sequencer turns into a flash cycle error.

Software programs the ranges through a small write port. It then raises a lockdown request. From that edge on, the ranges are frozen and protection is in force. Only a reset clears the lockdown. Before lockdown, no access is ever blocked, whatever the ranges hold.

Each range register is 32 bits wide:
- Bit 31 is the write/erase enable.
- Bits 28:16 hold the upper page number. This is address bits 24:12, with the low twelve bits taken as all ones.
- Bit 15 is the read enable.
- Bits 12:0 hold the lower page number. This is address bits 24:12, with the low twelve bits taken as zero.
- All other bits are always zero.

Top module: `flash_range_guard`

## Requirements
- R1: After reset, all five range registers read back as zero, `locked` is 0 and `chk_block` is 0.
- R2: While `locked` is 0, a cycle with `cfg_we`=1 and `cfg_sel` in 0..4 stores `cfg_wdata & 32'h9FFF_9FFF` into range `cfg_sel`, so bits 30:29 and 14:13 read as zero. The stored value is visible on `cfg_rdata` from the next cycle. `cfg_rdata` shows the range chosen by `cfg_sel`, and it is zero for `cfg_sel` 5..7. Writes to `cfg_sel` 5..7 change no range.
- R3: A cycle with `lock_set`=1 makes `locked` 1 from the next cycle. `locked` then stays 1 until reset. While `locked` is 1, writes change no range. A write in the same cycle as the first `lock_set` is still accepted.
- R4: While `locked` is 0, `chk_block` is 0 for every address and direction.
- R5: While `locked` is 1, a read (`chk_is_write`=0) is blocked when some range has bit 15 set and `lower*4096 <= chk_addr <= upper*4096 + 4095`.
- R6: While `locked` is 1, a write or erase (`chk_is_write`=1) is blocked under the same address test, using bit 31 in place of bit 15. A range enabled only for the other direction does not block.
- R7: Both limits are inclusive at byte level. A range whose upper page is below its lower page matches no address.
- R8: `chk_block` is the OR over all five ranges. A hit in any single range is enough to block.
- R9: `chk_block` is combinational from `chk_addr`, `chk_is_write`, the stored ranges and `locked`. It follows an address change within the same cycle, with no clock edge between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cfg_we | input | 1 | Range register write strobe |
| cfg_sel | input | 3 | Range index for writes and readback |
| cfg_wdata | input | 32 | Range register write value |
| cfg_rdata | output | 32 | Readback of the selected range register |
| lock_set | input | 1 | Lockdown request |
| locked | output | 1 | Sticky lockdown state |
| chk_addr | input | 25 | Linear address of the pending flash cycle |
| chk_is_write | input | 1 | 1 for a write or erase, 0 for a read |
| chk_block | output | 1 | The pending cycle is forbidden |

## Verification
Range writes and the lockdown request each pass through one register. The bench drives them at a falling edge and reads `cfg_rdata` or `locked` just after the next falling edge, once the single rising edge between has taken them in. The block decision has no register on its path. The bench therefore changes the address at a falling edge and samples `chk_block` one nanosecond later, and in one case it changes the address twice in a single cycle. Expected decisions come from a bench model of the ranges and the lockdown, which is updated only when the matching write or request has gone in.

// File: rtl/frg_pkg.sv
package frg_pkg;
  localparam int unsigned REG_W      = 32;
  localparam int unsigned ADDR_W     = 25;
  localparam int unsigned PAGE_SHIFT = 12;
  localparam int unsigned PAGE_W     = ADDR_W - PAGE_SHIFT;
  localparam int unsigned NUM_RANGES = 5;

  // field positions decoded by the matcher
  localparam int unsigned LO_LSB   = 0;
  localparam int unsigned RD_EN_B  = 15;
  localparam int unsigned HI_LSB   = 16;
  localparam int unsigned WR_EN_B  = 31;

  localparam logic [REG_W-1:0] LO_MASK  = REG_W'(((1 << PAGE_W) - 1) << LO_LSB);
  localparam logic [REG_W-1:0] HI_MASK  = REG_W'(((1 << PAGE_W) - 1) << HI_LSB);
  localparam logic [REG_W-1:0] EN_MASK  = (REG_W'(1) << RD_EN_B) | (REG_W'(1) << WR_EN_B);
  localparam logic [REG_W-1:0] KEEP_MASK = LO_MASK | HI_MASK | EN_MASK;

  typedef struct packed {
    logic              wr_en;
    logic              rd_en;
    logic [PAGE_W-1:0] hi_page;
    logic [PAGE_W-1:0] lo_page;
  } range_t;

  function automatic range_t unpack_range(input logic [REG_W-1:0] r);
    range_t f;
    f.wr_en   = r[WR_EN_B];
    f.rd_en   = r[RD_EN_B];
    f.hi_page = r[HI_LSB +: PAGE_W];
    f.lo_page = r[LO_LSB +: PAGE_W];
    return f;
  endfunction
endpackage

// File: rtl/frg_lock.sv
module frg_lock (
  input  logic clk,
  input  logic rst_n,
  input  logic lock_set,
  output logic lock_q
);
  logic lock_d;

  always_comb begin
    lock_d = lock_q | lock_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lock_q <= 1'b0;
    else        lock_q <= lock_d;
  end
endmodule

// File: rtl/frg_range_reg.sv
module frg_range_reg
  import frg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] q
);
  logic [REG_W-1:0] q_d;

  always_comb begin
    q_d = q;
    if (wr_en) q_d = wdata & KEEP_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= '0;
    else if (wr_en) q <= q_d;
  end
endmodule

// File: rtl/frg_range_match.sv
module frg_range_match
  import frg_pkg::*;
(
  input  logic [REG_W-1:0]  range_q,
  input  logic [ADDR_W-1:0] addr,
  input  logic              is_write,
  output logic              hit
);
  range_t            f;
  logic [PAGE_W-1:0] page;
  logic              dir_en;
  logic              in_span;

  always_comb begin
    f       = unpack_range(range_q);
    page    = addr[ADDR_W-1:PAGE_SHIFT];
    dir_en  = is_write ? f.wr_en : f.rd_en;
    // page compare equals byte compare with implied 0x000 / 0xFFF low bits
    in_span = (page >= f.lo_page) && (page <= f.hi_page);
    hit     = dir_en && in_span;
  end
endmodule

// File: rtl/flash_range_guard.sv
module flash_range_guard
  import frg_pkg::*;
#(
  parameter int unsigned N_RANGES = NUM_RANGES,
  localparam int unsigned SEL_W   = (N_RANGES > 1) ? $clog2(N_RANGES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [SEL_W-1:0]  cfg_sel,
  input  logic [REG_W-1:0]  cfg_wdata,
  output logic [REG_W-1:0]  cfg_rdata,
  input  logic              lock_set,
  output logic              locked,
  input  logic [ADDR_W-1:0] chk_addr,
  input  logic              chk_is_write,
  output logic              chk_block
);
  logic [REG_W-1:0]    range_q [N_RANGES];
  logic [N_RANGES-1:0] wr_en;
  logic [N_RANGES-1:0] hit;

  frg_lock u_lock (
    .clk      (clk),
    .rst_n    (rst_n),
    .lock_set (lock_set),
    .lock_q   (locked)
  );

  for (genvar i = 0; i < N_RANGES; i++) begin : g_range
    assign wr_en[i] = cfg_we && !locked && (cfg_sel == SEL_W'(i));

    frg_range_reg u_reg (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (wr_en[i]),
      .wdata (cfg_wdata),
      .q     (range_q[i])
    );

    frg_range_match u_match (
      .range_q  (range_q[i]),
      .addr     (chk_addr),
      .is_write (chk_is_write),
      .hit      (hit[i])
    );
  end

  always_comb begin
    cfg_rdata = '0;
    for (int i = 0; i < N_RANGES; i++) begin
      if (cfg_sel == SEL_W'(i)) cfg_rdata = range_q[i];
    end
  end

  assign chk_block = locked && (|hit);
endmodule

// File: rtl/frg_checker.sv
module frg_checker
  import frg_pkg::*;
#(
  parameter int unsigned N_RANGES = NUM_RANGES,
  parameter int unsigned SEL_W    = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_we,
  input logic [SEL_W-1:0]  cfg_sel,
  input logic [REG_W-1:0]  cfg_wdata,
  input logic [REG_W-1:0]  cfg_rdata,
  input logic              lock_set,
  input logic              locked,
  input logic              chk_block
);
  // R2: reserved bits never appear on readback
  p_rsv_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rdata & ~KEEP_MASK) == '0);

  // R2: an unlocked write lands, masked, when read back at the same index
  p_wr_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !locked && (int'(cfg_sel) < int'(N_RANGES)))
    |=> (cfg_sel != $past(cfg_sel)) || (cfg_rdata == ($past(cfg_wdata) & KEEP_MASK)));

  // R3: lockdown request takes effect next cycle
  p_lock_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
    lock_set |=> locked);

  // R3: lockdown is sticky
  p_lock_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> locked);

  // R3: writes after lockdown leave the selected range untouched
  p_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && cfg_we) |=> (cfg_sel != $past(cfg_sel)) || (cfg_rdata == $past(cfg_rdata)));

  // R4: nothing is blocked before lockdown
  p_open_unlocked_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !locked |-> !chk_block);
endmodule

bind flash_range_guard frg_checker #(
  .N_RANGES (N_RANGES),
  .SEL_W    (SEL_W)
) u_frg_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_we    (cfg_we),
  .cfg_sel   (cfg_sel),
  .cfg_wdata (cfg_wdata),
  .cfg_rdata (cfg_rdata),
  .lock_set  (lock_set),
  .locked    (locked),
  .chk_block (chk_block)
);

// File: tb/flash_range_guard_bench.sv
`timescale 1ns/1ps
module flash_range_guard_bench;
  logic        clk;
  logic        rst_n;
  logic        cfg_we;
  logic [2:0]  cfg_sel;
  logic [31:0] cfg_wdata;
  logic [31:0] cfg_rdata;
  logic        lock_set;
  logic        locked;
  logic [24:0] chk_addr;
  logic        chk_is_write;
  logic        chk_block;

  int n_chk;
  int n_bad;
  logic [31:0] m_reg [5];
  bit          m_lock;

  flash_range_guard u_flash_range_guard (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_we       (cfg_we),
    .cfg_sel      (cfg_sel),
    .cfg_wdata    (cfg_wdata),
    .cfg_rdata    (cfg_rdata),
    .lock_set     (lock_set),
    .locked       (locked),
    .chk_addr     (chk_addr),
    .chk_is_write (chk_is_write),
    .chk_block    (chk_block)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [31:0] mk(bit we, bit re, int lo, int hi);
    return {we, 2'b00, 13'(hi), re, 2'b00, 13'(lo)};
  endfunction

  function automatic bit exp_block(logic [24:0] a, bit wr);
    if (!m_lock) return 1'b0;
    for (int i = 0; i < 5; i++) begin
      logic [31:0] r;
      bit en;
      r  = m_reg[i];
      en = wr ? r[31] : r[15];
      if (en && (a[24:12] >= r[12:0]) && (a[24:12] <= r[28:16])) return 1'b1;
    end
    return 1'b0;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    cfg_we = 1'b0; lock_set = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 5; i++) m_reg[i] = '0;
    m_lock = 1'b0;
    @(negedge clk);
  endtask

  task automatic cfg_write(int sel, logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 3'(sel); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    if (!m_lock && sel < 5) m_reg[sel] = d & 32'h9FFF_9FFF;
  endtask

  task automatic do_lock();
    @(negedge clk);
    lock_set = 1'b1;
    @(negedge clk);
    lock_set = 1'b0;
    m_lock = 1'b1;
  endtask

  task automatic check_reg(int sel, string tag);
    cfg_sel = 3'(sel);
    #1;
    chk(tag, cfg_rdata, (sel < 5) ? m_reg[sel] : 32'h0);
  endtask

  task automatic check_addr(logic [24:0] a, bit wr, string tag);
    @(negedge clk);
    chk_addr = a; chk_is_write = wr;
    #1;
    chk(tag, {31'b0, chk_block}, {31'b0, exp_block(a, wr)});
  endtask

  function automatic logic [31:0] rand_range();
    int lo, hi;
    lo = int'($urandom_range(0, 8191));
    if ($urandom_range(0, 7) == 0) hi = (lo > 0) ? lo - 1 : 0;
    else begin
      hi = lo + int'($urandom_range(0, 40));
      if (hi > 8191) hi = 8191;
    end
    // random reserved bits exercise the mask
    return mk(1'($urandom), 1'($urandom), lo, hi) | ($urandom & 32'h6000_6000);
  endfunction

  function automatic logic [24:0] rand_addr();
    int r;
    logic [31:0] g;
    r = int'($urandom_range(0, 4));
    g = m_reg[r];
    case ($urandom_range(0, 4))
      0: return {g[12:0], 12'h000};
      1: return {g[28:16], 12'hFFF};
      2: return {g[12:0] - 13'd1, 12'hFFF};
      3: return {g[28:16] + 13'd1, 12'h000};
      default: return 25'($urandom);
    endcase
  endfunction

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd20240601));
    n_chk = 0; n_bad = 0;
    rst_n = 1'b0; cfg_we = 1'b0; cfg_sel = '0; cfg_wdata = '0;
    lock_set = 1'b0; chk_addr = '0; chk_is_write = 1'b0;
    do_reset();

    // R1 reset state
    chk("R1 locked", {31'b0, locked}, 32'h0);
    check_addr(25'h0, 1'b1, "R1 block");
    for (int i = 0; i < 5; i++) check_reg(i, "R1 reg");

    // R2 directed programming, reserved bits written as ones
    cfg_write(0, mk(1, 0, 13'h010, 13'h01F) | 32'h6000_6000);
    cfg_write(1, mk(0, 1, 13'h100, 13'h100));
    cfg_write(2, mk(1, 1, 13'h1FF0, 13'h1FFF));
    cfg_write(3, mk(1, 1, 13'h050, 13'h040));
    cfg_write(4, 32'h0);
    for (int i = 0; i < 5; i++) check_reg(i, "R2 readback");
    cfg_write(5, 32'hFFFF_FFFF);
    cfg_write(7, 32'hFFFF_FFFF);
    for (int i = 0; i < 8; i++) check_reg(i, "R2 out-of-range sel");

    // R4 nothing blocked before lockdown
    check_addr(25'h010000, 1'b1, "R4 unlocked write");
    check_addr(25'h100000, 1'b0, "R4 unlocked read");
    check_addr(25'h1FFFFFF, 1'b1, "R4 unlocked top");

    // R3 lockdown
    do_lock();
    chk("R3 locked", {31'b0, locked}, 32'h1);
    repeat (3) @(negedge clk);
    chk("R3 sticky", {31'b0, locked}, 32'h1);
    for (int i = 0; i < 5; i++) cfg_write(i, 32'hFFFF_FFFF);
    for (int i = 0; i < 5; i++) check_reg(i, "R3 frozen");

    // R6 R7 write range 0
    check_addr(25'h010000, 1'b1, "R6 R7 lower edge");
    check_addr(25'h00FFFF, 1'b1, "R7 below lower");
    check_addr(25'h01FFFF, 1'b1, "R7 upper edge");
    check_addr(25'h020000, 1'b1, "R7 above upper");
    check_addr(25'h010000, 1'b0, "R6 read on write-only range");
    // R5 read range 1, single page
    check_addr(25'h100000, 1'b0, "R5 page start");
    check_addr(25'h100FFF, 1'b0, "R5 page end");
    check_addr(25'h101000, 1'b0, "R5 past page");
    check_addr(25'h100800, 1'b1, "R5 write on read-only range");
    // R8 range 2 at the top, R7 inverted range 3
    check_addr(25'h1FFFFFF, 1'b0, "R8 top read");
    check_addr(25'h1FF0000, 1'b1, "R8 top write");
    check_addr(25'h045000, 1'b0, "R7 inverted read");
    check_addr(25'h045000, 1'b1, "R7 inverted write");

    // R9 two address changes within one cycle
    @(negedge clk);
    chk_addr = 25'h018000; chk_is_write = 1'b1;
    #1 chk("R9 first", {31'b0, chk_block}, 32'h1);
    chk_addr = 25'h030000;
    #1 chk("R9 second", {31'b0, chk_block}, 32'h0);

    // R1 reset clears lockdown and ranges
    do_reset();
    chk("R1 relock cleared", {31'b0, locked}, 32'h0);
    check_reg(2, "R1 reg cleared");

    // random phase: R2 R4 then R3 R5 R6 R7 R8
    for (int round = 0; round < 4; round++) begin
      do_reset();
      for (int i = 0; i < 5; i++) cfg_write(i, rand_range());
      for (int i = 0; i < 5; i++) check_reg(i, "R2 random readback");
      for (int k = 0; k < 40; k++) check_addr(rand_addr(), 1'($urandom), "R4 random");
      do_lock();
      cfg_write(int'($urandom_range(0, 4)), $urandom);
      for (int i = 0; i < 5; i++) check_reg(i, "R3 random frozen");
      for (int k = 0; k < 300; k++) check_addr(rand_addr(), 1'($urandom), "R5 R6 R8 random");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule